// File: doc/BRIEF.md
# Line-Rate Horizontal Timing Pulse Generator

This block produces the per-line timing strobes of a digital video front end from a line-locked pixel clock. A free-running horizontal position counter covers one full video line. Four pulses are decoded from it: a black-level clamp strobe, a horizontal sync indicator for the analog side, a fixed-width horizontal sync, and a horizontal reference that frames the active luma samples. The clamp, indicator and sync positions are programmable in steps of 8 clocks.

Two register banks hold the pulse positions, one for 50 Hz lines and one for 60 Hz lines. The `mode60` input picks the bank and also sets the line length. Software writes the banks through a plain address/data write port. Writes land in staging registers and become active only at the next line boundary, so a line never shows half of an old setting.

The `rst_n` pin releases the output drivers as soon as it goes low. It resets the internal state only after it has stayed low long enough. The `side_drive` input decides whether the clamp and indicator pins are driven at all.

Top module: `htg_top`

## Requirements
- R1: `hs_o` is high for exactly 128 consecutive clocks once per line.
- R2: The rising edge of `hs_o` lies 8×(sync position register) clocks after line start, using the bank of the current mode. A pulse that reaches past the line end continues at the start of the next line.
- R3: `clamp_o` is high from position 8×start up to, but not including, position 8×end, using the clamp pair of the current mode. When start equals end the pulse never goes high.
- R4: `ind_o` follows the same rule as R3, using its own start/end pair in each bank.
- R5: When end is below start, the clamp and indicator pulses run from start through the line end and on up to end in the next line.
- R6: `href_o` rises 150 clocks (50 Hz) or 180 clocks (60 Hz) after line start. It stays high for 1536 clocks (768 samples × 2) or 1280 clocks (640 samples × 2), on every line without exception.
- R7: While `side_drive` is 0, `side_oe` is 0, so the clamp and indicator pins are not driven.
- R8: While `rst_n` is low, `timing_oe` and `side_oe` are both 0.
- R9: A low period on `rst_n` of 30 or more rising edges resets the block. After that reset, every register is zero (sync at position 0, clamp and indicator never high), and `href_o` is first seen high in the 151st cycle after release. A low period of 29 edges or fewer leaves the line timing undisturbed.
- R10: A line is 1728 clocks when `mode60` is 0 and 1716 clocks when it is 1. `mode60` is sampled only at a line boundary.
- R11: Write map: address bit 3 picks the bank (0 = 50 Hz, 1 = 60 Hz). Address bits 2:0 pick the field: 0 = clamp start, 1 = clamp end, 2 = indicator start, 3 = indicator end, 4 = sync position.
- R12: A write takes effect at the start of the next line. A pulse later in the current line keeps the old position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Active-low reset with minimum-length qualification |
| mode60 | input | 1 | 1 selects the 60 Hz bank and line length |
| side_drive | input | 1 | 1 drives the clamp and indicator pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| clamp_o | output | 1 | Clamp strobe |
| ind_o | output | 1 | Horizontal sync indicator |
| hs_o | output | 1 | Fixed-width horizontal sync |
| href_o | output | 1 | Active-sample reference |
| side_oe | output | 1 | Output enable for clamp_o and ind_o |
| timing_oe | output | 1 | Output enable for hs_o and href_o |

## Verification
The bench targets several corner cases:
- **Wrapping pulses.** Pulses that cross the line end are tested in both modes. A window decoder without wrap handling would give a pulse count of zero, or would give the complement of the intended window.
- **Equal start and end.** This setting is tested as well. A design that got it wrong would keep the pin high for a whole line.
- **Mid-line writes.** A write is made in the middle of a line. If the position shadowing were missing, the sync would jump to the new place within the same line.
- **Reset filter limits.** The reset length is checked on both sides of the limit: 29 edges must leave the href period at exactly one line, and 30 edges must restart the counter so that href appears 151 cycles after release.

// File: rtl/htg_pkg.sv
package htg_pkg;

  localparam int POS_W = 16;
  localparam int REG_W = 8;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic [2:0] {
    F_CLAMP_ON  = 3'd0,
    F_CLAMP_OFF = 3'd1,
    F_IND_ON    = 3'd2,
    F_IND_OFF   = 3'd3,
    F_HS_AT     = 3'd4
  } field_e;

  typedef struct packed {
    reg_t clamp_on;
    reg_t clamp_off;
    reg_t ind_on;
    reg_t ind_off;
    reg_t hs_at;
  } bank_t;

  // Register value to clock position.
  function automatic pos_t step_pos(input reg_t v, input int step);
    return pos_t'(int'(v) * step);
  endfunction

  // Addition modulo the line length.
  function automatic pos_t wrap_add(input pos_t a, input pos_t b, input pos_t len);
    logic [POS_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, len}) s = s - {1'b0, len};
    return s[POS_W-1:0];
  endfunction

  // Start/end window; end below start wraps, equal means empty.
  function automatic logic in_window(input pos_t pos, input pos_t on, input pos_t off);
    if (on == off)     return 1'b0;
    else if (on < off) return (pos >= on) && (pos < off);
    else               return (pos >= on) || (pos < off);
  endfunction

  // Fixed-width window starting at 'at', wrapping across the line end.
  function automatic logic fixed_window(input pos_t pos, input pos_t at,
                                        input pos_t width, input pos_t len);
    pos_t d;
    if (pos >= at) d = pos - at;
    else           d = pos + len - at;
    return d < width;
  endfunction

endpackage

// File: rtl/htg_reset_gate.sv
module htg_reset_gate #(
  parameter int MIN_LOW = 30
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst_n)
      low_cnt <= '0;
    else if (low_cnt != CW'(MIN_LOW))
      low_cnt <= low_cnt + 1'b1;
  end

  // Qualified on the MIN_LOW-th consecutive low edge.
  assign core_rst = !rst_n && (low_cnt >= CW'(MIN_LOW - 1));

endmodule

// File: rtl/htg_line_counter.sv
module htg_line_counter
  import htg_pkg::*;
#(
  parameter int LINE50 = 1728,
  parameter int LINE60 = 1716
) (
  input  logic clk,
  input  logic rst,
  input  logic mode60_act,
  output pos_t hcount,
  output logic line_end
);
  pos_t len;

  assign len      = mode60_act ? pos_t'(LINE60) : pos_t'(LINE50);
  assign line_end = (hcount == len - pos_t'(1));

  always_ff @(posedge clk) begin
    if (rst)           hcount <= '0;
    else if (line_end) hcount <= '0;
    else               hcount <= hcount + pos_t'(1);
  end

endmodule

// File: rtl/htg_cfg_regs.sv
module htg_cfg_regs
  import htg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  reg_t          wr_data,
  input  logic          mode60_req,
  input  logic          line_end,
  output bank_t         act_cfg,
  output logic          act_mode60
);
  localparam int NBANK = 2;

  bank_t stage_w [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_t q;
    logic  hit;

    assign hit = wr_en && (wr_addr[AW-1] == b[0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (hit) begin
        case (field_e'(wr_addr[2:0]))
          F_CLAMP_ON:  q.clamp_on  <= wr_data;
          F_CLAMP_OFF: q.clamp_off <= wr_data;
          F_IND_ON:    q.ind_on    <= wr_data;
          F_IND_OFF:   q.ind_off   <= wr_data;
          F_HS_AT:     q.hs_at     <= wr_data;
          default:     q           <= q;
        endcase
      end
    end

    assign stage_w[b] = q;
  end

  // Shadow copy: settings and mode change only at a line boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg    <= '0;
      act_mode60 <= 1'b0;
    end else if (line_end) begin
      act_cfg    <= stage_w[mode60_req];
      act_mode60 <= mode60_req;
    end
  end

  if (AW > 4) begin : g_unused
    logic unused_hi;
    assign unused_hi = ^wr_addr[AW-2:3];
  end

endmodule

// File: rtl/htg_pulse_gen.sv
module htg_pulse_gen
  import htg_pkg::*;
#(
  parameter int LINE50    = 1728,
  parameter int LINE60    = 1716,
  parameter int STEP      = 8,
  parameter int HS_W      = 128,
  parameter int HREF_ST50 = 150,
  parameter int HREF_ST60 = 180,
  parameter int SMP50     = 768,
  parameter int SMP60     = 640,
  parameter int CPS       = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  pos_t  hcount,
  input  bank_t act_cfg,
  input  logic  act_mode60,
  output logic  clamp_q,
  output logic  ind_q,
  output logic  hs_q,
  output logic  href_q
);
  localparam int HREF_LEN50 = SMP50 * CPS;
  localparam int HREF_LEN60 = SMP60 * CPS;

  pos_t len, href_on, href_off;
  logic clamp_d, ind_d, hs_d, href_d;

  always_comb begin
    len      = act_mode60 ? pos_t'(LINE60) : pos_t'(LINE50);
    href_on  = act_mode60 ? pos_t'(HREF_ST60) : pos_t'(HREF_ST50);
    href_off = wrap_add(href_on,
                        act_mode60 ? pos_t'(HREF_LEN60) : pos_t'(HREF_LEN50), len);
    clamp_d  = in_window(hcount, step_pos(act_cfg.clamp_on, STEP),
                         step_pos(act_cfg.clamp_off, STEP));
    ind_d    = in_window(hcount, step_pos(act_cfg.ind_on, STEP),
                         step_pos(act_cfg.ind_off, STEP));
    hs_d     = fixed_window(hcount, step_pos(act_cfg.hs_at, STEP), pos_t'(HS_W), len);
    href_d   = in_window(hcount, href_on, href_off);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_q <= 1'b0;
      ind_q   <= 1'b0;
      hs_q    <= 1'b0;
      href_q  <= 1'b0;
    end else begin
      clamp_q <= clamp_d;
      ind_q   <= ind_d;
      hs_q    <= hs_d;
      href_q  <= href_d;
    end
  end

endmodule

// File: rtl/htg_top.sv
module htg_top
  import htg_pkg::*;
#(
  parameter int LINE50    = 1728,
  parameter int LINE60    = 1716,
  parameter int STEP      = 8,
  parameter int HS_W      = 128,
  parameter int HREF_ST50 = 150,
  parameter int HREF_ST60 = 180,
  parameter int SMP50     = 768,
  parameter int SMP60     = 640,
  parameter int CPS       = 2,
  parameter int MIN_LOW   = 30,
  parameter int AW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode60,
  input  logic          side_drive,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          clamp_o,
  output logic          ind_o,
  output logic          hs_o,
  output logic          href_o,
  output logic          side_oe,
  output logic          timing_oe
);
  // Named internal events, observed by the bound checker.
  logic  core_rst;
  logic  line_end;
  logic  act_mode60;
  pos_t  hcount;
  bank_t act_cfg;

  htg_reset_gate #(.MIN_LOW(MIN_LOW)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_rst (core_rst)
  );

  htg_line_counter #(.LINE50(LINE50), .LINE60(LINE60)) u_cnt (
    .clk        (clk),
    .rst        (core_rst),
    .mode60_act (act_mode60),
    .hcount     (hcount),
    .line_end   (line_end)
  );

  htg_cfg_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst        (core_rst),
    .wr_en      (wr_en && !core_rst),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mode60_req (mode60),
    .line_end   (line_end),
    .act_cfg    (act_cfg),
    .act_mode60 (act_mode60)
  );

  htg_pulse_gen #(
    .LINE50(LINE50), .LINE60(LINE60), .STEP(STEP), .HS_W(HS_W),
    .HREF_ST50(HREF_ST50), .HREF_ST60(HREF_ST60),
    .SMP50(SMP50), .SMP60(SMP60), .CPS(CPS)
  ) u_pulse (
    .clk        (clk),
    .rst        (core_rst),
    .hcount     (hcount),
    .act_cfg    (act_cfg),
    .act_mode60 (act_mode60),
    .clamp_q    (clamp_o),
    .ind_q      (ind_o),
    .hs_q       (hs_o),
    .href_q     (href_o)
  );

  // Drivers release at once on a low reset pin, without qualification.
  assign timing_oe = rst_n;
  assign side_oe   = rst_n && side_drive;

endmodule

// File: rtl/htg_chk.sv
module htg_chk
  import htg_pkg::*;
#(
  parameter int LINE50 = 1728,
  parameter int LINE60 = 1716,
  parameter int HS_W   = 128,
  parameter int SMP50  = 768,
  parameter int SMP60  = 640,
  parameter int CPS    = 2
) (
  input logic  clk,
  input logic  rst_n,
  input logic  side_drive,
  input logic  side_oe,
  input logic  timing_oe,
  input logic  hs_o,
  input logic  href_o,
  input logic  line_end,
  input logic  act_mode60,
  input pos_t  hcount,
  input bank_t act_cfg
);
  logic [15:0] hs_run, href_run;
  logic        hs_arm, href_arm, hs_prev, href_prev;
  bank_t       cfg_prev;
  logic        mode_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_run <= '0; href_run <= '0;
      hs_arm <= 1'b0; href_arm <= 1'b0;
      hs_prev <= 1'b0; href_prev <= 1'b0;
      cfg_prev <= act_cfg; mode_prev <= act_mode60;
    end else begin
      hs_prev   <= hs_o;
      href_prev <= href_o;
      cfg_prev  <= act_cfg;
      mode_prev <= act_mode60;
      hs_run    <= hs_o ? hs_run + 16'd1 : 16'd0;
      href_run  <= href_o ? href_run + 16'd1 : 16'd0;
      // A settings change may cut a pulse that crosses the boundary.
      if ((cfg_prev != act_cfg) || (mode_prev != act_mode60)) begin
        hs_arm <= 1'b0; href_arm <= 1'b0;
      end else begin
        if (!hs_o)   hs_arm   <= 1'b1;
        if (!href_o) href_arm <= 1'b1;
      end
    end
  end

  // R1: a full sync run is exactly HS_W clocks
  a_r1_hs_width: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_arm && hs_prev && !hs_o) |-> (hs_run == 16'(HS_W)));

  // R6: a full reference run matches the sample count of the active mode
  a_r6_href_width: assert property (@(posedge clk) disable iff (!rst_n)
    (href_arm && href_prev && !href_o) |->
      (href_run == (act_mode60 ? 16'(SMP60 * CPS) : 16'(SMP50 * CPS))));

  // R10: position stays inside the current line
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcount < (act_mode60 ? pos_t'(LINE60) : pos_t'(LINE50)));

  // R12: active settings move only right after a line end
  a_r12_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> ($stable(act_cfg) && $stable(act_mode60)));

  // R7: side pins released when not selected as outputs
  a_r7_side_release: assert property (@(posedge clk) disable iff (!rst_n)
    !side_drive |-> !side_oe);

  // R8: no driver enabled while the reset pin is low
  always_comb begin
    a_r8_tristate: assert (rst_n || (!timing_oe && !side_oe));
  end

endmodule

bind htg_top htg_chk #(
  .LINE50(LINE50), .LINE60(LINE60), .HS_W(HS_W),
  .SMP50(SMP50), .SMP60(SMP60), .CPS(CPS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .side_drive (side_drive),
  .side_oe    (side_oe),
  .timing_oe  (timing_oe),
  .hs_o       (hs_o),
  .href_o     (href_o),
  .line_end   (line_end),
  .act_mode60 (act_mode60),
  .hcount     (hcount),
  .act_cfg    (act_cfg)
);

// File: tb/sim_htg_top.sv
module sim_htg_top;

  localparam int L50 = 1728;
  localparam int L60 = 1716;
  localparam int NV  = 4;
  // mode, clamp on, clamp off, ind on, ind off, hs at,
  // exp clamp clocks, exp ind clocks, exp href clocks,
  // exp hs rise offset from href rise, exp clamp rise offset
  localparam int VEC [NV][11] = '{
    '{0,  20,  30,  10,  40,  50,   80,  240, 1536,  250,   10},
    '{0, 200,  10,   5,   5, 210,  208,    0, 1536, 1530, 1450},
    '{1, 100, 120, 200,   2,   0,  160,  132, 1280, 1536,  620},
    '{1,  30,  20,   0, 214, 212, 1636, 1712, 1280, 1516,   60}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode60 = 1'b0;
  logic       side_drive = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       clamp_o, ind_o, hs_o, href_o, side_oe, timing_oe;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  htg_top u0 (
    .clk(clk), .rst_n(rst_n), .mode60(mode60), .side_drive(side_drive),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clamp_o(clamp_o), .ind_o(ind_o), .hs_o(hs_o), .href_o(href_o),
    .side_oe(side_oe), .timing_oe(timing_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // sel: 0 href, 1 hs
  task automatic wait_rise(input int sel);
    logic p, c;
    p = (sel == 0) ? href_o : hs_o;
    forever begin
      @(negedge clk);
      c = (sel == 0) ? href_o : hs_o;
      if (!p && c) break;
      p = c;
    end
  endtask

  task automatic hold_reset(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (n) @(posedge clk);
    #1;
    check(!timing_oe && !side_oe, "R8 oe low in reset", int'({timing_oe, side_oe}), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic measure(input int len, output int c_cl, output int c_in, output int c_hs,
                         output int c_hr, output int off_hs, output int off_cl);
    logic p_hs, p_cl;
    c_cl = 0; c_in = 0; c_hs = 0; c_hr = 0; off_hs = -1; off_cl = -1;
    p_hs = hs_o; p_cl = clamp_o;
    for (int i = 0; i < len; i++) begin
      c_cl += int'(clamp_o); c_in += int'(ind_o);
      c_hs += int'(hs_o);    c_hr += int'(href_o);
      if (hs_o && !p_hs && off_hs < 0) off_hs = i;
      if (clamp_o && !p_cl && off_cl < 0) off_cl = i;
      p_hs = hs_o; p_cl = clamp_o;
      @(negedge clk);
    end
  endtask

  task automatic program_vec(input int v);
    int b;
    b = VEC[v][0] * 8;
    wr(b + 0, VEC[v][1]); wr(b + 1, VEC[v][2]);
    wr(b + 2, VEC[v][3]); wr(b + 3, VEC[v][4]);
    wr(b + 4, VEC[v][5]);
    mode60 = VEC[v][0][0];
    wait_rise(0);
    wait_rise(0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL timeout R1 actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    int j, c_cl, c_in, c_hs, c_hr, o_hs, o_cl;
    time t0, t1, t2;

    // Reset state and release timing (R8, R9)
    hold_reset(40);
    j = 0;
    do begin
      @(negedge clk);
      j++;
      if (j == 1) begin
        check(hs_o == 1'b1, "R9 default sync at position 0", int'(hs_o), 1);
        check(timing_oe == 1'b1, "R8 driven after release", int'(timing_oe), 1);
      end
    end while (!href_o && j < 4000);
    check(j == 151, "R9 first href cycle after reset", j, 151);

    // Defaults: clamp and indicator off, sync width (R3, R4, R1)
    measure(L50, c_cl, c_in, c_hs, c_hr, o_hs, o_cl);
    check(c_cl == 0, "R3 equal start/end never high", c_cl, 0);
    check(c_in == 0, "R4 equal start/end never high", c_in, 0);
    check(c_hs == 128, "R1 sync width default", c_hs, 128);

    // Table-driven configurations (R1..R6, R10, R11)
    for (int v = 0; v < NV; v++) begin
      program_vec(v);
      measure(VEC[v][0] ? L60 : L50, c_cl, c_in, c_hs, c_hr, o_hs, o_cl);
      check(c_cl == VEC[v][6],  $sformatf("R3/R5 clamp clocks vec%0d", v), c_cl, VEC[v][6]);
      check(c_in == VEC[v][7],  $sformatf("R4/R5 ind clocks vec%0d", v), c_in, VEC[v][7]);
      check(c_hs == 128,        $sformatf("R1 sync clocks vec%0d", v), c_hs, 128);
      check(c_hr == VEC[v][8],  $sformatf("R6 href clocks vec%0d", v), c_hr, VEC[v][8]);
      check(o_hs == VEC[v][9],  $sformatf("R2/R11 sync offset vec%0d", v), o_hs, VEC[v][9]);
      check(o_cl == VEC[v][10], $sformatf("R3/R11 clamp offset vec%0d", v), o_cl, VEC[v][10]);
    end

    // Mid-line write takes effect only at the next line (R12)
    program_vec(0);
    wait_rise(0);
    t0 = $time;
    wr(4, 100);
    wait_rise(1);
    t1 = $time;
    check((t1 - t0) / 4 == 250, "R12 current line keeps old sync", int'((t1 - t0) / 4), 250);
    wait_rise(1);
    t2 = $time;
    check((t2 - t1) / 4 == 2128, "R12 new sync next line", int'((t2 - t1) / 4), 2128);

    // Side pin direction (R7)
    @(negedge clk);
    side_drive = 1'b0;
    @(negedge clk);
    check(side_oe == 1'b0, "R7 side pins released", int'(side_oe), 0);
    check(timing_oe == 1'b1, "R7 timing pins still driven", int'(timing_oe), 1);
    side_drive = 1'b1;
    @(negedge clk);
    check(side_oe == 1'b1, "R7 side pins driven", int'(side_oe), 1);

    // Short reset keeps line phase; line length 1728 (R9, R10)
    wait_rise(0);
    t1 = $time;
    hold_reset(29);
    wait_rise(0);
    t2 = $time;
    check((t2 - t1) / 4 == L50, "R9/R10 29-edge reset keeps href period", int'((t2 - t1) / 4), L50);

    // Exactly 30 low edges resets (R9)
    hold_reset(30);
    j = 0;
    do begin
      @(negedge clk);
      j++;
    end while (!href_o && j < 4000);
    check(j == 151, "R9 30-edge reset restarts line", j, 151);

    // 60 Hz line length via href period (R10)
    program_vec(2);
    t1 = $time;
    wait_rise(0);
    t2 = $time;
    check((t2 - t1) / 4 == L60, "R10 60 Hz line length", int'((t2 - t1) / 4), L60);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule